// File: doc/BRIEF.md
# Indirect Interrupt Register Access Router

This block sits between a hart's indirect register access port and the interrupt file that holds pending bits, enable bits, a delivery switch and a priority threshold for each page. A single request carries the privilege level, a virtualisation flag, a guest selector, an 8-bit register select, the access width (32 or 64 bits), write data and a write mask. The router works out which page the request belongs to and which register it names. It returns the value that was there before the access and applies the masked update in the same cycle. Requests that are not legal are answered with an error flag.

Two build variants exist. A machine-level instance owns exactly one page. A supervisor-level instance owns page 0 plus guest pages 1 to NUM_PAGES-1. Each page drives one interrupt line. The line is high when delivery is on and some identity is both pending and enabled below the threshold. The top-interrupt register reports the winning identity, and writing it claims that identity, which clears its pending bit.

Top module: `irr_router`

## Requirements
- R1: With MMODE=1, only requests with privilege 2'b11 and the virtualisation flag clear are accepted, and they use page 0. Every other request gets an error response.
- R2: With MMODE=0, a request with privilege 2'b01 and the virtualisation flag clear uses page 0. With the flag set, it uses the page equal to the guest selector, which must lie in 1..NUM_PAGES-1. A guest selector outside that range, or any privilege other than 2'b01, gives an error.
- R3: The register selects are: 0x70 delivery enable (bit 0); 0x72 threshold (bits TH_W-1:0); 0x76 top interrupt; 0x80+g pending group g; 0xC0+g enable group g (g = 0..63). Every other select gives an error.
- R4: In 32-bit mode, group g covers identities 32g..32g+31 on data bits 31:0, and read bits 63:32 are zero. In 64-bit mode, an odd g gives an error, and an even g covers identities 64(g/2)..64(g/2)+63.
- R5: A group whose index (g, or g/2 in 64-bit mode) is at least NUM_IRQ divided by the access width gives an error.
- R6: Every accepted request returns the register's previous value. The new value is (old AND NOT mask) OR (data AND mask), applied bit by bit.
- R7: Identity 0 is never pending or enabled. Bit 0 of group 0 reads as zero and ignores writes.
- R8: Top interrupt reads as the lowest identity i ≥ 1 that is pending, enabled and below the limit, placed in bits 15:0 and again in bits 31:16. It reads 0 when there is none. The limit is the threshold when that value is nonzero and at most NUM_IRQ; otherwise the limit is NUM_IRQ.
- R9: A top-interrupt access with a nonzero write mask returns the identity found before the access and clears that identity's pending bit. With a zero mask the access changes nothing.
- R10: irq_out[p], one cycle after a response, equals (delivery of page p) AND (top interrupt of page p is nonzero), judged on the state left by that request.
- R11: rsp_valid is high for exactly the cycle after each request. An error response has rsp_err high and rsp_rdata zero, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_priv | input | 2 | Privilege level (2'b11 machine, 2'b01 supervisor) |
| req_virt | input | 1 | Virtualisation flag |
| req_guest | input | PW | Guest selector |
| req_sel | input | 8 | Register select |
| req_w64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_wdata | input | 64 | Write data |
| req_wmask | input | 64 | Write mask, one bit per data bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Illegal access |
| rsp_rdata | output | 64 | Previous register value |
| irq_out | output | NUM_PAGES | Interrupt line per page |

## Verification
A single top-interrupt request does two things in one cycle: it reports the winning identity and it removes that identity from the pending set. The very next request then sees a different winner. The bench issues claim requests back to back on one page, with several pending identities spread across two 64-bit groups, one of them disabled and some of them near the threshold. Each returned value is judged against the lowest eligible identity that an arithmetic model computes before that claim. The interrupt line is checked to drop one cycle after the final claim empties the page.

// File: rtl/irr_pkg.sv
package irr_pkg;
  typedef enum logic [2:0] {
    K_DLV,
    K_THR,
    K_TOP,
    K_PEND,
    K_EN
  } reg_kind_e;

  localparam logic [7:0] SEL_DLV  = 8'h70;
  localparam logic [7:0] SEL_THR  = 8'h72;
  localparam logic [7:0] SEL_TOP  = 8'h76;
  localparam logic [1:0] PRIV_S   = 2'b01;
  localparam logic [1:0] PRIV_M   = 2'b11;
  localparam int         TOP_SHIFT = 16;
endpackage

// File: rtl/irr_decode.sv
module irr_decode import irr_pkg::*; #(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int NUM_IRQ   = 128,
  parameter int PW        = 2,
  parameter int BW        = 8
) (
  input  logic [1:0]    priv,
  input  logic          virt,
  input  logic [PW-1:0] guest,
  input  logic [7:0]    sel,
  input  logic          w64,
  output logic          err,
  output logic [PW-1:0] page,
  output reg_kind_e     kind,
  output logic [BW-1:0] base
);
  logic       priv_bad, sel_bad, grp_bad;
  logic [5:0] grp, gidx;

  // Page selection from privilege, virtualisation and guest number
  always_comb begin
    priv_bad = 1'b0;
    page     = '0;
    if (MMODE) begin
      priv_bad = !(priv == PRIV_M && !virt);
    end else if (priv != PRIV_S) begin
      priv_bad = 1'b1;
    end else if (virt) begin
      if (guest == '0 || 32'(guest) >= NUM_PAGES) priv_bad = 1'b1;
      else page = guest;
    end
  end

  // Register kind and group range
  always_comb begin
    grp     = sel[5:0];
    gidx    = w64 ? {1'b0, grp[5:1]} : grp;
    sel_bad = 1'b0;
    grp_bad = 1'b0;
    kind    = K_DLV;
    if (sel == SEL_DLV)      kind = K_DLV;
    else if (sel == SEL_THR) kind = K_THR;
    else if (sel == SEL_TOP) kind = K_TOP;
    else if (sel[7])         kind = sel[6] ? K_EN : K_PEND;
    else                     sel_bad = 1'b1;
    if (!sel_bad && (kind == K_PEND || kind == K_EN)) begin
      grp_bad = (w64 && grp[0]) ||
                (32'(gidx) >= (w64 ? NUM_IRQ / 64 : NUM_IRQ / 32));
    end
    base = BW'({26'd0, gidx} << (w64 ? 6 : 5));
    err  = priv_bad | sel_bad | grp_bad;
  end
endmodule

// File: rtl/irr_scan.sv
module irr_scan #(
  parameter int NUM_IRQ = 128,
  parameter int TH_W    = 11,
  parameter int IDW     = 7
) (
  input  logic [NUM_IRQ-1:0] pend,
  input  logic [NUM_IRQ-1:0] en,
  input  logic [TH_W-1:0]    thr,
  output logic [IDW-1:0]     id
);
  int lim;

  always_comb begin
    lim = ((thr != '0) && (int'(thr) <= NUM_IRQ)) ? int'(thr) : NUM_IRQ;
    id  = '0;
    // Walk downwards so the lowest eligible identity wins
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (pend[i] && en[i] && (i < lim)) id = IDW'(i);
    end
  end
endmodule

// File: rtl/irr_router.sv
module irr_router import irr_pkg::*; #(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int NUM_IRQ   = 128,
  parameter int TH_W      = 11,
  localparam int PW       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int IDW      = $clog2(NUM_IRQ),
  localparam int BW       = IDW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [1:0]           req_priv,
  input  logic                 req_virt,
  input  logic [PW-1:0]        req_guest,
  input  logic [7:0]           req_sel,
  input  logic                 req_w64,
  input  logic [63:0]          req_wdata,
  input  logic [63:0]          req_wmask,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [63:0]          rsp_rdata,
  output logic [NUM_PAGES-1:0] irq_out
);
  logic [NUM_PAGES-1:0][NUM_IRQ-1:0] pend_q, pend_d, en_q, en_d;
  logic [NUM_PAGES-1:0][TH_W-1:0]    thr_q, thr_d;
  logic [NUM_PAGES-1:0]              dlv_q, dlv_d, irq_d;
  logic [NUM_PAGES-1:0][IDW-1:0]     top_id;

  logic          derr;
  logic [PW-1:0] dpage;
  reg_kind_e     dkind;
  logic [BW-1:0] dbase;
  logic [63:0]   rd;
  logic [IDW-1:0] tid;
  logic [TH_W-1:0] tmask;
  int idx;

  irr_decode #(
    .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .NUM_IRQ(NUM_IRQ), .PW(PW), .BW(BW)
  ) u_dec (
    .priv(req_priv), .virt(req_virt), .guest(req_guest), .sel(req_sel),
    .w64(req_w64), .err(derr), .page(dpage), .kind(dkind), .base(dbase)
  );

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    irr_scan #(.NUM_IRQ(NUM_IRQ), .TH_W(TH_W), .IDW(IDW)) u_scan (
      .pend(pend_q[p]), .en(en_q[p]), .thr(thr_q[p]), .id(top_id[p])
    );
    assign irq_d[p] = dlv_q[p] && (top_id[p] != '0);

    assert_id0_clear_R7: assert property (@(posedge clk) disable iff (rst)
      !pend_q[p][0] && !en_q[p][0]);
    assert_irq_needs_dlv_R10: assert property (@(posedge clk) disable iff (rst)
      irq_out[p] |-> $past(dlv_q[p]));
  end

  // Read old value and build the next state
  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    thr_d  = thr_q;
    dlv_d  = dlv_q;
    rd     = '0;
    idx    = 0;
    tid    = top_id[dpage];
    tmask  = req_wmask[TH_W-1:0];
    if (req_valid && !derr) begin
      case (dkind)
        K_DLV: begin
          rd[0] = dlv_q[dpage];
          if (req_wmask[0]) dlv_d[dpage] = req_wdata[0];
        end
        K_THR: begin
          rd[TH_W-1:0] = thr_q[dpage];
          thr_d[dpage] = (thr_q[dpage] & ~tmask) | (req_wdata[TH_W-1:0] & tmask);
        end
        K_TOP: begin
          rd[IDW-1:0]         = tid;
          rd[TOP_SHIFT +: IDW] = tid;
          if ((tid != '0) && (req_wmask != '0)) pend_d[dpage][tid] = 1'b0;
        end
        default: begin
          for (int b = 0; b < 64; b++) begin
            if ((b < 32) || req_w64) begin
              idx = int'(dbase) + b;
              if (idx < NUM_IRQ) begin
                rd[b] = (dkind == K_PEND) ? pend_q[dpage][IDW'(idx)]
                                          : en_q[dpage][IDW'(idx)];
                if ((idx != 0) && req_wmask[b]) begin
                  if (dkind == K_PEND) pend_d[dpage][IDW'(idx)] = req_wdata[b];
                  else                 en_d[dpage][IDW'(idx)]   = req_wdata[b];
                end
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      en_q      <= '0;
      thr_q     <= '0;
      dlv_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      irq_out   <= '0;
    end else begin
      pend_q    <= pend_d;
      en_q      <= en_d;
      thr_q     <= thr_d;
      dlv_q     <= dlv_d;
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && derr;
      rsp_rdata <= rd;
      irq_out   <= irq_d;
    end
  end

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_err_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && derr) |=> (pend_q == $past(pend_q) && en_q == $past(en_q) &&
                             thr_q == $past(thr_q) && dlv_q == $past(dlv_q)));
  assert_err_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));
endmodule

// File: tb/tb_irr_router.sv
module tb_irr_router;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NI = 128;
  localparam int TW = 11;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          vs = 1'b0, vm = 1'b0;
  logic [1:0]    priv = '0;
  logic          virt = 1'b0;
  logic [PW-1:0] guest = '0;
  logic [7:0]    sel = '0;
  logic          w64 = 1'b0;
  logic [63:0]   wd = '0, wm = '0;

  logic s_rv, s_err, m_rv, m_err;
  logic [63:0] s_rd, m_rd;
  logic [NP-1:0] s_irq;
  logic [0:0] m_irq;

  irr_router #(.MMODE(1'b0), .NUM_PAGES(NP), .NUM_IRQ(NI), .TH_W(TW)) dut (
    .clk(clk), .rst(rst), .req_valid(vs), .req_priv(priv), .req_virt(virt),
    .req_guest(guest), .req_sel(sel), .req_w64(w64), .req_wdata(wd),
    .req_wmask(wm), .rsp_valid(s_rv), .rsp_err(s_err), .rsp_rdata(s_rd),
    .irq_out(s_irq)
  );

  irr_router #(.MMODE(1'b1), .NUM_PAGES(1), .NUM_IRQ(NI), .TH_W(TW)) dut_m (
    .clk(clk), .rst(rst), .req_valid(vm), .req_priv(priv), .req_virt(virt),
    .req_guest(guest[0]), .req_sel(sel), .req_w64(w64), .req_wdata(wd),
    .req_wmask(wm), .rsp_valid(m_rv), .rsp_err(m_err), .rsp_rdata(m_rd),
    .irq_out(m_irq)
  );

  // Model state; index NP belongs to the machine-level instance
  logic [NI-1:0] mp [NP+1];
  logic [NI-1:0] me [NP+1];
  logic          md [NP+1];
  logic [TW-1:0] mt [NP+1];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int mtop(input int p);
    int lim;
    lim = (mt[p] != 0 && int'(mt[p]) <= NI) ? int'(mt[p]) : NI;
    for (int i = 1; i < lim; i++) if (mp[p][i] && me[p][i]) return i;
    return 0;
  endfunction

  task automatic model(input bit mm, input logic [1:0] pv, input logic vt, input int gs,
                       input int sl, input bit x64, input logic [63:0] d,
                       input logic [63:0] m, output bit e, output logic [63:0] r);
    int p, g, gi, wdt, id;
    bit ispend;
    e = 1'b0; r = '0; p = 0; ispend = 1'b0;
    g = sl % 64; wdt = x64 ? 64 : 32; gi = x64 ? g / 2 : g;
    if (mm) begin
      if (!(pv == 2'b11 && vt == 1'b0)) e = 1'b1;
    end else if (pv != 2'b01) e = 1'b1;
    else if (vt) begin
      if (gs == 0 || gs >= NP) e = 1'b1; else p = gs;
    end
    if (sl == 'h70 || sl == 'h72 || sl == 'h76) begin
    end else if (sl >= 'h80 && sl <= 'hFF) begin
      ispend = (sl < 'hC0);
      if (x64 && (g % 2 == 1)) e = 1'b1;
      if (gi >= NI / wdt) e = 1'b1;
    end else e = 1'b1;
    if (e) return;
    if (mm) p = NP;
    if (sl == 'h70) begin
      r[0] = md[p];
      if (m[0]) md[p] = d[0];
    end else if (sl == 'h72) begin
      r[TW-1:0] = mt[p];
      mt[p] = (mt[p] & ~m[TW-1:0]) | (d[TW-1:0] & m[TW-1:0]);
    end else if (sl == 'h76) begin
      id = mtop(p);
      r = (64'(id) << 16) | 64'(id);
      if (id != 0 && m != 0) mp[p][id] = 1'b0;
    end else begin
      for (int b = 0; b < wdt; b++) begin
        id = gi * wdt + b;
        r[b] = ispend ? mp[p][id] : me[p][id];
        if (id != 0 && m[b]) begin
          if (ispend) mp[p][id] = d[b]; else me[p][id] = d[b];
        end
      end
    end
  endtask

  task automatic acc(input string tag, input bit mm, input logic [1:0] pv, input logic vt,
                     input int gs, input int sl, input bit x64,
                     input logic [63:0] d, input logic [63:0] m);
    bit e;
    logic [63:0] r;
    model(mm, pv, vt, gs, sl, x64, d, m, e, r);
    priv = pv; virt = vt; guest = PW'(gs); sel = 8'(sl); w64 = x64; wd = d; wm = m;
    if (mm) vm = 1'b1; else vs = 1'b1;
    @(posedge clk); #1;
    vs = 1'b0; vm = 1'b0;
    if (mm) begin
      chk({tag, " R11 valid"}, {63'd0, m_rv}, 64'd1);
      chk({tag, " err"}, {63'd0, m_err}, {63'd0, e});
      chk({tag, " rdata"}, m_rd, r);
    end else begin
      chk({tag, " R11 valid"}, {63'd0, s_rv}, 64'd1);
      chk({tag, " err"}, {63'd0, s_err}, {63'd0, e});
      chk({tag, " rdata"}, s_rd, r);
    end
  endtask

  // Route to a page of the supervisor instance
  task automatic pacc(input string tag, input int p, input int sl, input bit x64,
                      input logic [63:0] d, input logic [63:0] m);
    acc(tag, 1'b0, 2'b01, p != 0, p, sl, x64, d, m);
  endtask

  task automatic chk_irq(input string tag);
    @(posedge clk); #1;
    for (int p = 0; p < NP; p++)
      chk({tag, " R10 irq"}, {63'd0, s_irq[p]}, {63'd0, md[p] && (mtop(p) != 0)});
    chk({tag, " R10 irq m"}, {63'd0, m_irq[0]}, {63'd0, md[NP] && (mtop(NP) != 0)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int p = 0; p <= NP; p++) begin
      mp[p] = '0; me[p] = '0; md[p] = 1'b0; mt[p] = '0;
    end
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    chk("reset R11 rsp_valid", {63'd0, s_rv}, 64'd0);
    chk("reset R10 irq", {60'd0, s_irq}, 64'd0);
    chk("reset R11 m rsp_valid", {63'd0, m_rv}, 64'd0);

    // R2: page decode sweep, thresholds marking each page
    for (int p = 0; p < NP; p++) pacc("R2 mark", p, 'h72, 1'b0, 64'(p * 3 + 7), '1);
    for (int pv = 0; pv < 4; pv++)
      for (int vt = 0; vt < 2; vt++)
        for (int gs = 0; gs < NP; gs++)
          acc("R2 decode", 1'b0, 2'(pv), 1'(vt), gs, 'h72, 1'b0, 64'(100 + gs), 64'h0);

    // R1: machine instance accepts only machine non-virtual
    for (int pv = 0; pv < 4; pv++)
      for (int vt = 0; vt < 2; vt++)
        for (int gs = 0; gs < 2; gs++)
          acc("R1 decode", 1'b1, 2'(pv), 1'(vt), gs, 'h72, 1'b0, 64'(pv * 4 + vt * 2 + gs + 1), '1);
    acc("R1 readback", 1'b1, 2'b11, 1'b0, 0, 'h72, 1'b0, 64'h0, 64'h0);

    // R3 R4 R5: every select at both widths
    for (int sl = 0; sl < 256; sl++)
      for (int x = 0; x < 2; x++)
        pacc("R3 R4 R5 select", 0, sl, 1'(x), 64'h0, 64'h0);

    // R6 R4: patterns on every page and group
    for (int p = 0; p < NP; p++)
      for (int g = 0; g < 4; g++)
        pacc("R6 en32", p, 'hC0 + g, 1'b0,
             64'(p) * 64'h1357_9BDF_2468_ACE1 + 64'(g) * 64'h0F0F_1234_5678_9ABD, '1);
    for (int p = 0; p < NP; p++)
      for (int g = 0; g < 2; g++) begin
        pacc("R6 pend64 a", p, 'h80 + 2 * g, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_FF00_F0F3);
        pacc("R6 pend64 b", p, 'h80 + 2 * g, 1'b1, 64'h0123_4567_89AB_CDEF ^ 64'(p), 64'h00FF_FF00_0F0F_3C3C);
      end
    for (int p = 0; p < NP; p++)
      for (int g = 0; g < 4; g++) begin
        pacc("R4 R6 read pend32", p, 'h80 + g, 1'b0, 64'h0, 64'h0);
        pacc("R4 R6 read en64", p, 'hC0 + (g & 2), 1'b1, 64'h0, 64'h0);
      end

    // R7: identity 0 is read-only zero
    pacc("R7 write id0", 2, 'h80, 1'b0, '1, '1);
    pacc("R7 read id0", 2, 'h80, 1'b0, 64'h0, 64'h0);
    pacc("R7 en id0", 2, 'hC0, 1'b1, '1, 64'h1);
    pacc("R7 en id0 read", 2, 'hC0, 1'b1, 64'h0, 64'h0);
    chk_irq("idle");

    // R8 R9 R10: priority, threshold and claims on page 1
    pacc("R8 clr p", 1, 'h80, 1'b1, 64'h0, '1);
    pacc("R8 clr p", 1, 'h82, 1'b1, 64'h0, '1);
    pacc("R8 en", 1, 'hC0, 1'b1, '1, '1);
    pacc("R8 en", 1, 'hC2, 1'b1, '1, '1);
    pacc("R8 set", 1, 'h80, 1'b1, (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 12) | (64'd1 << 40), '1);
    pacc("R8 set", 1, 'h82, 1'b1, 64'd1 << 36, '1);
    pacc("R8 dis12", 1, 'hC0, 1'b1, 64'h0, 64'd1 << 12);
    pacc("R8 thr0", 1, 'h72, 1'b0, 64'd0, '1);
    pacc("R8 top", 1, 'h76, 1'b0, 64'h0, 64'h0);
    pacc("R8 thr9", 1, 'h72, 1'b0, 64'd9, '1);
    pacc("R8 top thr9", 1, 'h76, 1'b0, 64'h0, 64'h0);
    pacc("R8 thr5", 1, 'h72, 1'b0, 64'd5, '1);
    pacc("R8 top thr5", 1, 'h76, 1'b0, 64'h0, 64'h0);
    pacc("R8 thr big", 1, 'h72, 1'b0, 64'd2000, '1);
    pacc("R8 top thr big", 1, 'h76, 1'b0, 64'h0, 64'h0);
    pacc("R8 thr0", 1, 'h72, 1'b0, 64'd0, '1);
    pacc("R10 dlv", 1, 'h70, 1'b0, 64'd1, 64'd1);
    chk_irq("R10 on");
    pacc("R9 nomask", 1, 'h76, 1'b0, '1, 64'h0);
    pacc("R9 nomask", 1, 'h76, 1'b0, '1, 64'h0);
    for (int k = 0; k < 5; k++) pacc("R9 claim", 1, 'h76, 1'b0, 64'h0, 64'h1);
    chk_irq("R10 off");
    pacc("R8 readback", 1, 'h80, 1'b1, 64'h0, 64'h0);

    // R11: illegal writes change nothing
    acc("R11 bad guest", 1'b0, 2'b01, 1'b1, 0, 'h80, 1'b1, '1, '1);
    pacc("R11 odd w64", 3, 'h81, 1'b1, '1, '1);
    pacc("R11 beyond", 3, 'h84, 1'b0, '1, '1);
    pacc("R11 readback", 3, 'h80, 1'b1, 64'h0, 64'h0);
    pacc("R11 readback", 3, 'h82, 1'b1, 64'h0, 64'h0);

    // Machine instance delivery
    acc("R1 en", 1'b1, 2'b11, 1'b0, 0, 'hC0, 1'b0, 64'd8, '1);
    acc("R1 thr0", 1'b1, 2'b11, 1'b0, 0, 'h72, 1'b0, 64'd0, '1);
    acc("R1 pend", 1'b1, 2'b11, 1'b0, 0, 'h80, 1'b0, 64'd8, '1);
    acc("R1 dlv", 1'b1, 2'b11, 1'b0, 0, 'h70, 1'b0, 64'd1, 64'd1);
    chk_irq("R1 m on");
    acc("R1 top", 1'b1, 2'b11, 1'b0, 0, 'h76, 1'b0, 64'h0, 64'h1);
    chk_irq("R1 m off");

    finish_run();
  end
endmodule